// File: doc/BRIEF.md
# Register Context Retention Controller

This block keeps a copy of a display subsystem's configuration registers across a power-off of their domain. Before the domain is switched off, a power manager pulses `suspend_req`. The controller then reads the selected registers over a simple register port and stores each word in a shadow memory. When power is back, the manager pulses `resume_req` and the controller writes the stored words back.

A strap input, `link_present`, tells the controller whether the serial display link is fitted. It is sampled when a sequence is accepted. With the strap low, only the main control register is handled. With the strap high, the serial-link control register and the PLL control register are handled as well. The shadow memory covers the whole 512-byte register window, one word per 32-bit register, and its index is the byte offset divided by four.

A restore request is only carried out once a save has completed. Until then it writes nothing and simply reports done.

Top module: `ctx_retain`

## Requirements
- R1: After synchronous reset, `ctx_valid`, `reg_rd`, `reg_wr`, `save_done` and `restore_done` are all 0.
- R2: With `link_present` low when a save is accepted, exactly one read is issued, at byte offset 0x40, in the cycle after the accepting clock edge.
- R3: With `link_present` high when a save is accepted, reads are issued at byte offsets 0x40, 0x44 and 0x48, in that order, on consecutive cycles starting the cycle after acceptance. Every read address is word aligned (bits [1:0] are 0).
- R4: `save_done` is a one-cycle pulse that appears two cycles after the last read cycle. `ctx_valid` rises in that same cycle and stays high until reset.
- R5: A resume accepted while `ctx_valid` is 0 causes no register write. `restore_done` pulses in the cycle right after the accepting edge.
- R6: A resume accepted while `ctx_valid` is 1 and `link_present` is high writes the words captured by the most recent save. The writes go to 0x40, 0x44 and 0x48 in that order, one per cycle, starting two cycles after acceptance. `restore_done` pulses once, in the cycle after the last write.
- R7: A resume accepted with `link_present` low writes only offset 0x40, using the word captured by the most recent save.
- R8: A request that arrives while a sequence is running is held and started once the controller is idle again. When a save and a restore are both waiting, the save is started first.
- R9: The controller issues at most one register access per cycle; `reg_rd` and `reg_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_present | input | 1 | Strap: serial display link fitted |
| suspend_req | input | 1 | Request to save context (one-cycle pulse) |
| resume_req | input | 1 | Request to restore context (one-cycle pulse) |
| reg_rd | output | 1 | Register read strobe; data returns on `reg_rdata` one cycle later |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 9 | Byte offset within the register window |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |
| save_done | output | 1 | One-cycle pulse at the end of a save |
| restore_done | output | 1 | One-cycle pulse at the end of a restore |
| ctx_valid | output | 1 | A saved context exists |

## Verification
The hardest situation to reach from the ports is a request colliding with a sequence that is already running, especially a save and a restore both waiting at the moment the controller goes idle. The stimulus creates this by pulsing suspend and then resume while a save is still issuing reads. It then fires both requests in the same cycle from idle. The bench also changes the register contents after a save, so that a restore can be seen returning the captured words rather than the current ones. It toggles the strap between save and restore, so that a three-word save followed by a one-word restore is covered.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SV_ISSUE,
    ST_SV_WAIT,
    ST_RS_ISSUE,
    ST_RS_WAIT
  } seq_st_t;

endpackage

// File: rtl/ctx_req_hold.sv
module ctx_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic want
);
  logic held;

  always_ff @(posedge clk) begin
    if (rst)       held <= 1'b0;
    else if (take) held <= 1'b0;
    else if (req)  held <= 1'b1;
  end

  assign want = req | held;
endmodule

// File: rtl/ctx_shadow_ram.sv
module ctx_shadow_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int AW       = 9,
  parameter int DW       = 32,
  parameter int IW       = 7,
  parameter int CTRL_OFS = 'h40,
  parameter int LINK_OFS = 'h44,
  parameter int PLL_OFS  = 'h48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_en,
  input  logic          want_save,
  input  logic          want_rest,
  output logic          take_save,
  output logic          take_rest,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          ram_we,
  output logic [IW-1:0] ram_widx,
  output logic [DW-1:0] ram_wdata,
  output logic [IW-1:0] ram_ridx,
  input  logic [DW-1:0] ram_rdata,
  output logic          save_done,
  output logic          restore_done,
  output logic          ctx_valid
);
  seq_st_t       st;
  logic [1:0]    step, last_step;
  logic          is_last;
  logic [AW-1:0] cur_ofs;
  logic [IW-1:0] cur_idx;

  // save pipeline
  logic          rd_last;
  logic [IW-1:0] rd_idx;
  logic          cap_v, cap_last;
  logic [IW-1:0] cap_idx;
  // restore pipeline
  logic          p1_v, p1_last;
  logic [AW-1:0] p1_addr;
  logic          wr_last;

  // fixed order: control, serial-link control, PLL control
  function automatic logic [AW-1:0] ofs_of(input logic [1:0] s);
    case (s)
      2'd0:    ofs_of = AW'(CTRL_OFS);
      2'd1:    ofs_of = AW'(LINK_OFS);
      default: ofs_of = AW'(PLL_OFS);
    endcase
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [1:0] s);
    case (s)
      2'd0:    idx_of = IW'(CTRL_OFS / 4);
      2'd1:    idx_of = IW'(LINK_OFS / 4);
      default: idx_of = IW'(PLL_OFS / 4);
    endcase
  endfunction

  assign cur_ofs   = ofs_of(step);
  assign cur_idx   = idx_of(step);
  assign is_last   = (step == last_step);
  assign take_save = (st == ST_IDLE) && want_save;
  assign take_rest = (st == ST_IDLE) && !want_save && want_rest;

  assign ram_we    = cap_v;
  assign ram_widx  = cap_idx;
  assign ram_wdata = reg_rdata;
  assign ram_ridx  = cur_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      step         <= '0;
      last_step    <= '0;
      reg_rd       <= 1'b0;
      reg_wr       <= 1'b0;
      reg_addr     <= '0;
      reg_wdata    <= '0;
      rd_last      <= 1'b0;
      rd_idx       <= '0;
      cap_v        <= 1'b0;
      cap_last     <= 1'b0;
      cap_idx      <= '0;
      p1_v         <= 1'b0;
      p1_last      <= 1'b0;
      p1_addr      <= '0;
      wr_last      <= 1'b0;
      save_done    <= 1'b0;
      restore_done <= 1'b0;
      ctx_valid    <= 1'b0;
    end else begin
      reg_rd       <= 1'b0;
      rd_last      <= 1'b0;
      p1_v         <= 1'b0;
      save_done    <= 1'b0;
      restore_done <= 1'b0;

      cap_v    <= reg_rd;
      cap_idx  <= rd_idx;
      cap_last <= rd_last;

      reg_wr  <= p1_v;
      wr_last <= p1_v & p1_last;
      if (p1_v) begin
        reg_addr  <= p1_addr;
        reg_wdata <= ram_rdata;
      end

      case (st)
        ST_IDLE: begin
          step      <= '0;
          last_step <= link_en ? 2'd2 : 2'd0;
          if (take_save)                  st <= ST_SV_ISSUE;
          else if (take_rest && ctx_valid) st <= ST_RS_ISSUE;
          else if (take_rest)             restore_done <= 1'b1;
        end
        ST_SV_ISSUE: begin
          reg_rd   <= 1'b1;
          reg_addr <= cur_ofs;
          rd_idx   <= cur_idx;
          rd_last  <= is_last;
          step     <= 2'(step + 2'd1);
          if (is_last) st <= ST_SV_WAIT;
        end
        ST_SV_WAIT: begin
          if (cap_v && cap_last) begin
            save_done <= 1'b1;
            ctx_valid <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_RS_ISSUE: begin
          p1_v    <= 1'b1;
          p1_addr <= cur_ofs;
          p1_last <= is_last;
          step    <= 2'(step + 2'd1);
          if (is_last) st <= ST_RS_WAIT;
        end
        ST_RS_WAIT: begin
          if (reg_wr && wr_last) begin
            restore_done <= 1'b1;
            st           <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_retain.sv
module ctx_retain #(
  parameter int DW        = 32,
  parameter int WIN_BYTES = 512,
  parameter int CTRL_OFS  = 'h40,
  parameter int LINK_OFS  = 'h44,
  parameter int PLL_OFS   = 'h48,
  localparam int AW       = $clog2(WIN_BYTES),
  localparam int DEPTH    = WIN_BYTES / 4,
  localparam int IW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_present,
  input  logic          suspend_req,
  input  logic          resume_req,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          save_done,
  output logic          restore_done,
  output logic          ctx_valid
);
  logic          want_save, want_rest, take_save, take_rest;
  logic          ram_we;
  logic [IW-1:0] ram_widx, ram_ridx;
  logic [DW-1:0] ram_wdata, ram_rdata;

  ctx_req_hold u_hold_save (
    .clk(clk), .rst(rst), .req(suspend_req), .take(take_save), .want(want_save)
  );

  ctx_req_hold u_hold_rest (
    .clk(clk), .rst(rst), .req(resume_req), .take(take_rest), .want(want_rest)
  );

  ctx_shadow_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .widx(ram_widx), .wdata(ram_wdata),
    .ridx(ram_ridx), .rdata(ram_rdata)
  );

  ctx_seq #(
    .AW(AW), .DW(DW), .IW(IW),
    .CTRL_OFS(CTRL_OFS), .LINK_OFS(LINK_OFS), .PLL_OFS(PLL_OFS)
  ) u_seq (
    .clk(clk), .rst(rst), .link_en(link_present),
    .want_save(want_save), .want_rest(want_rest),
    .take_save(take_save), .take_rest(take_rest),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_widx(ram_widx), .ram_wdata(ram_wdata),
    .ram_ridx(ram_ridx), .ram_rdata(ram_rdata),
    .save_done(save_done), .restore_done(restore_done), .ctx_valid(ctx_valid)
  );
endmodule

// File: rtl/ctx_retain_chk.sv
module ctx_retain_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [1:0] addr_lo,
  input logic       save_done,
  input logic       restore_done,
  input logic       ctx_valid
);
  p_one_access_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> (addr_lo == 2'b00));

  p_save_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    save_done |=> !save_done);

  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ctx_valid |=> ctx_valid);

  p_valid_from_save_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctx_valid) |-> save_done);

  p_no_write_unsaved_r5: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> ctx_valid);

  p_restore_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    restore_done |=> !restore_done);
endmodule

bind ctx_retain ctx_retain_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .addr_lo(reg_addr[1:0]), .save_done(save_done),
  .restore_done(restore_done), .ctx_valid(ctx_valid)
);

// File: tb/ctx_retain_test.sv
module ctx_retain_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_present = 1'b0;
  logic        suspend_req = 1'b0;
  logic        resume_req = 1'b0;
  logic        reg_rd, reg_wr;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic        save_done, restore_done, ctx_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_retain uut (
    .clk(clk), .rst(rst), .link_present(link_present),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .save_done(save_done), .restore_done(restore_done), .ctx_valid(ctx_valid)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag = "R1";

  // register file model, pokes applied at the clock edge
  logic [31:0] regs [128];
  logic        poke_en = 1'b0;
  logic [8:0]  poke_ofs = '0;
  logic [31:0] poke_val = '0;

  always @(posedge clk) begin
    if (reg_wr)  regs[reg_addr[8:2]] <= reg_wdata;
    if (reg_rd)  reg_rdata <= regs[reg_addr[8:2]];
    if (poke_en) regs[poke_ofs[8:2]] <= poke_val;
  end

  // behavioural reference: expected outputs per edge index
  int          cyc = 0;
  int          idle_at = 0;
  int          valid_at = -1;
  bit          sp = 0, rp = 0;
  bit          e_rd [int];
  bit          e_wr [int];
  bit          e_sd [int];
  bit          e_rn [int];
  logic [8:0]  e_addr [int];
  logic [31:0] e_wd [int];
  logic [31:0] shadow [int];

  function automatic logic [8:0] ofs_k(int k);
    return (k == 0) ? 9'h040 : (k == 1) ? 9'h044 : 9'h048;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      idle_at = cyc + 1; valid_at = -1; sp = 0; rp = 0;
    end else if (cyc >= idle_at) begin
      int n;
      n = link_present ? 3 : 1;
      if (suspend_req || sp) begin
        sp = 0;
        rp = rp | resume_req;
        for (int k = 0; k < n; k++) begin
          e_rd[cyc+1+k]   = 1;
          e_addr[cyc+1+k] = ofs_k(k);
          shadow[ofs_k(k)] = regs[ofs_k(k) >> 2];
        end
        e_sd[cyc+n+2] = 1;
        if (valid_at < 0) valid_at = cyc + n + 2;
        idle_at = cyc + n + 3;
      end else if (resume_req || rp) begin
        rp = 0;
        if (valid_at >= 0 && cyc > valid_at) begin
          for (int k = 0; k < n; k++) begin
            e_wr[cyc+2+k]   = 1;
            e_addr[cyc+2+k] = ofs_k(k);
            e_wd[cyc+2+k]   = shadow[ofs_k(k)];
          end
          e_rn[cyc+n+2] = 1;
          idle_at = cyc + n + 3;
        end else begin
          e_rn[cyc] = 1;
          idle_at = cyc + 1;
        end
      end
    end else begin
      sp = sp | suspend_req;
      rp = rp | resume_req;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare against the reference on every cycle, away from the edge
  always @(negedge clk) begin
    bit xr, xw, xs, xn, xv;
    xr = e_rd.exists(cyc);
    xw = e_wr.exists(cyc);
    xs = e_sd.exists(cyc);
    xn = e_rn.exists(cyc);
    xv = (valid_at >= 0) && (cyc >= valid_at);
    if (cyc > 0) begin
      chk(reg_rd === xr, "reg_rd", 32'(reg_rd), 32'(xr));
      chk(reg_wr === xw, "reg_wr", 32'(reg_wr), 32'(xw));
      chk(save_done === xs, "save_done", 32'(save_done), 32'(xs));
      chk(restore_done === xn, "restore_done", 32'(restore_done), 32'(xn));
      chk(ctx_valid === xv, "ctx_valid", 32'(ctx_valid), 32'(xv));
      if (xr || xw)
        chk(reg_addr === e_addr[cyc], "reg_addr", 32'(reg_addr), 32'(e_addr[cyc]));
      if (xw)
        chk(reg_wdata === e_wd[cyc], "reg_wdata", reg_wdata, e_wd[cyc]);
      // R9: single access per cycle
      chk(!(reg_rd && reg_wr), "R9 rd+wr", 32'({reg_rd, reg_wr}), 32'h0);
    end
  end

  task automatic poke(input logic [8:0] ofs, input logic [31:0] val);
    @(negedge clk);
    poke_en = 1'b1; poke_ofs = ofs; poke_val = val;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic pulse_sus;
    @(negedge clk); suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
  endtask

  task automatic pulse_res;
    @(negedge clk); resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 32'h1000 + 32'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    chk(ctx_valid === 1'b0, "reset ctx_valid", 32'(ctx_valid), 32'h0);
    poke(9'h040, 32'hA1A1_0040);
    poke(9'h044, 32'hB1B1_0044);
    poke(9'h048, 32'hC1C1_0048);

    tag = "R5"; link_present = 1'b1;
    pulse_res(); idle(6);

    tag = "R2"; link_present = 1'b0;
    pulse_sus(); idle(8);

    tag = "R7";
    poke(9'h040, 32'hDEAD_0040);
    pulse_res(); idle(8);
    chk(regs[16] === 32'hA1A1_0040, "R7 restored ctrl", regs[16], 32'hA1A1_0040);

    tag = "R3"; link_present = 1'b1;
    poke(9'h044, 32'h2222_0044);
    poke(9'h048, 32'h3333_0048);
    pulse_sus(); idle(10);

    tag = "R6";
    poke(9'h040, 32'h0);
    poke(9'h044, 32'h0);
    poke(9'h048, 32'h0);
    pulse_res(); idle(10);
    chk(regs[18] === 32'h3333_0048, "R6 restored pll", regs[18], 32'h3333_0048);

    tag = "R7"; link_present = 1'b0;
    poke(9'h044, 32'h5555_5555);
    pulse_res(); idle(8);
    chk(regs[17] === 32'h5555_5555, "R7 link reg untouched", regs[17], 32'h5555_5555);

    tag = "R8"; link_present = 1'b1;
    pulse_sus();
    pulse_res();
    idle(20);
    @(negedge clk); suspend_req = 1'b1; resume_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0; resume_req = 1'b0;
    idle(20);
    pulse_res();
    pulse_sus();
    pulse_sus();
    idle(30);

    tag = "R4";
    chk(ctx_valid === 1'b1, "R4 valid held", 32'(ctx_valid), 32'h1);
    idle(2);
    finish_run();
  end
endmodule